// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Standby

This block receives asynchronous serial characters on a single line. It runs from the system clock and is paced by a one-cycle tick enable that pulses sixteen times per bit period. The line first passes through a synchronizer. The receiver then watches the idle-high line for a falling edge and confirms the start bit at its centre. It samples every later bit three times around mid-bit and decides each bit by majority vote. The result is either an 8-bit or a 9-bit character, delivered least significant bit first into a receive data register. When a character completes, the block raises a full flag and an interrupt request. It also reports noise, framing errors and overruns.

For systems with several receivers on one line, software can place the receiver in standby. A receiver in standby keeps loading every character it receives into the data register, but it does not raise the full flag and it requests no interrupt. Standby ends by itself once the receiver has seen the line idle for one whole character time. A one-cycle read strobe acknowledges a character and clears the flags.

Top module: `uart_os_rx`

## Requirements
- R1: After reset the data register reads 0, and full, noise, framing, overrun, standby and interrupt are all 0.
- R2: Reception starts only on a high-to-low transition of the synchronized line, taken at a tick. If the majority of the start-bit samples is 1, the receiver drops the attempt and returns to idle search. No flag and no data change.
- R3: Each bit is sampled at sub-ticks 8, 9 and 10 of its 16 (the edge tick is sub-tick 1) and decided by 2-of-3 majority. Data arrives least significant bit first. In 8-bit mode data_o[8] is loaded as 0.
- R4: With nine_bit_i high at the start edge, nine data bits are received into data_o[8:0].
- R5: The line passes a two-flop synchronizer. The character completes at the tick that is 154 ticks (8-bit) or 170 ticks (9-bit) after the edge tick, counting the edge tick as the first. Outputs update on that clock edge.
- R6: noise_o is loaded as 1 when the three samples of the start, any data or the stop bit of a loaded character disagree.
- R7: A stop bit decided as 0 loads frame_err_o as 1, and the character is still loaded.
- R8: A character that completes while full_o is 1 sets overrun_o. It leaves data_o, noise_o and frame_err_o unchanged.
- R9: rd_i clears full_o, overrun_o, noise_o and frame_err_o on the next edge.
- R10: standby_set_i sets standby_o. Characters completed in standby are loaded into data_o but do not set full_o.
- R11: irq_o is high when full_o or overrun_o is high and standby_o is low.
- R12: Standby clears at the tick on which the receiver has been idle with the line high for 160 (8-bit) or 176 (9-bit) consecutive ticks. A shorter gap leaves standby set.
- R13: Characters are received without error when the transmitter bit time is about 3% shorter or 3% longer than 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sampling enable, 16 pulses per bit |
| rxd_i | input | 1 | Serial line, idle high |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| standby_set_i | input | 1 | Pulse that enters standby |
| rd_i | input | 1 | Read strobe, clears the flags |
| data_o | output | 9 | Receive data register |
| full_o | output | 1 | Character waiting |
| noise_o | output | 1 | Sample disagreement in the loaded character |
| frame_err_o | output | 1 | Stop bit was 0 |
| overrun_o | output | 1 | Character lost while full |
| standby_o | output | 1 | Standby active |
| irq_o | output | 1 | Receiver interrupt request |

## Verification
The bound checker checks several properties on every cycle. The full flag cannot rise while standby is active. The data register holds while a character is waiting. A read clears every flag. Full, interrupt and standby release change only on tick cycles, and a standby request always takes effect. Other behaviour can only be shown by the bench's scenarios, because each depends on a whole frame or a long idle stretch: the exact completion tick, majority voting under a glitch, false-start rejection, 8-bit masking after a 9-bit character, overrun, the idle-time release of standby, and tolerance to fast and slow transmitters. For these, the bench's tick-level reference model is compared with every output on every clock.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    // Which part of the frame the receiver is working on
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_vote.sv
module rx_vote (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic maj_o,
    output logic noisy_o
);
    // 2-of-3 majority; disagreement when some but not all samples are 1
    assign maj_o   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    assign noisy_o = (a_i | b_i | c_i) & ~(a_i & b_i & c_i);
endmodule

// File: rtl/rx_idle_cnt.sv
module rx_idle_cnt #(
    parameter int OVS      = 16,
    parameter int DATA_MAX = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic line_i,
    input  logic idle_i,
    input  logic restart_i,
    input  logic nine_i,
    output logic clr_o
);
    localparam int LIM_LONG  = OVS * (DATA_MAX + 2);
    localparam int LIM_SHORT = OVS * (DATA_MAX + 1);
    localparam int CW        = $clog2(LIM_LONG + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;
    logic [CW:0]   cnt_inc;

    assign lim     = nine_i ? CW'(LIM_LONG) : CW'(LIM_SHORT);
    assign cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (idle_i && line_i) begin
                if (cnt_q < lim) cnt_d = cnt_inc[CW-1:0];
            end else begin
                cnt_d = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // Release pulse on the tick that completes a full character of idle line
    assign clr_o = tick_i && idle_i && line_i && !restart_i && (cnt_inc >= {1'b0, lim});
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DATA_MAX    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic                rxd_i,
    input  logic                nine_bit_i,
    input  logic                standby_set_i,
    input  logic                rd_i,
    output logic [DATA_MAX-1:0] data_o,
    output logic                full_o,
    output logic                noise_o,
    output logic                frame_err_o,
    output logic                overrun_o,
    output logic                standby_o,
    output logic                irq_o
);
    localparam int SW = $clog2(OVS);
    localparam int BW = $clog2(DATA_MAX + 1);
    // sub-tick indices are RT number minus one
    localparam logic [SW-1:0] SUB_A    = SW'(OVS / 2 - 1);
    localparam logic [SW-1:0] SUB_B    = SW'(OVS / 2);
    localparam logic [SW-1:0] SUB_C    = SW'(OVS / 2 + 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);

    typedef struct packed {
        rx_state_e           st;
        logic [SW-1:0]       sub;
        logic [BW-1:0]       bitn;
        logic                nine;
        logic [DATA_MAX-1:0] shreg;
        logic [1:0]          smp;
        logic                nacc;
        logic [DATA_MAX-1:0] data;
        logic                full;
        logic                noise;
        logic                ferr;
        logic                ovr;
        logic                stby;
        logic                last_line;
    } rx_regs_t;

    localparam rx_regs_t RX_RESET = '{
        st: RX_IDLE, sub: '0, bitn: '0, nine: 1'b0, shreg: '0, smp: '0,
        nacc: 1'b0, data: '0, full: 1'b0, noise: 1'b0, ferr: 1'b0,
        ovr: 1'b0, stby: 1'b0, last_line: 1'b1
    };

    rx_regs_t q, n;

    logic                line;
    logic                maj, noisy;
    logic                idle_clr;
    logic [SW-1:0]       sub_nx;
    logic [BW-1:0]       last_bit;
    logic [DATA_MAX-1:0] dmask;

    rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rxd_i),
        .q_o    (line)
    );

    rx_vote vote_i (
        .a_i     (q.smp[0]),
        .b_i     (q.smp[1]),
        .c_i     (line),
        .maj_o   (maj),
        .noisy_o (noisy)
    );

    rx_idle_cnt #(.OVS(OVS), .DATA_MAX(DATA_MAX)) idle_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .line_i    (line),
        .idle_i    (q.st == RX_IDLE),
        .restart_i (standby_set_i),
        .nine_i    (nine_bit_i),
        .clr_o     (idle_clr)
    );

    assign sub_nx   = q.sub + 1'b1;
    assign last_bit = q.nine ? BW'(DATA_MAX) : BW'(DATA_MAX - 1);
    assign dmask    = q.nine ? {DATA_MAX{1'b1}} : {1'b0, {(DATA_MAX-1){1'b1}}};

    always_comb begin
        n = q;

        // read acknowledge applies before any completion in the same cycle
        if (rd_i) begin
            n.full  = 1'b0;
            n.ovr   = 1'b0;
            n.noise = 1'b0;
            n.ferr  = 1'b0;
        end

        if (tick_i) begin
            n.last_line = line;
            if (q.st == RX_IDLE) begin
                if (q.last_line && !line) begin
                    n.st   = RX_START;
                    n.sub  = '0;
                    n.bitn = '0;
                    n.nine = nine_bit_i;
                    n.nacc = 1'b0;
                end
            end else begin
                n.sub = sub_nx;
                if (sub_nx == SUB_A) n.smp[0] = line;
                if (sub_nx == SUB_B) n.smp[1] = line;
                if (sub_nx == SUB_C) begin
                    case (q.st)
                        RX_START: begin
                            if (maj) n.st   = RX_IDLE;
                            else     n.nacc = noisy;
                        end
                        RX_DATA: begin
                            for (int i = 0; i < DATA_MAX; i++) begin
                                if (q.bitn == BW'(i + 1)) n.shreg[i] = maj;
                            end
                            n.nacc = q.nacc | noisy;
                        end
                        RX_STOP: begin
                            n.st = RX_IDLE;
                            if (n.full) begin
                                n.ovr = 1'b1;
                            end else begin
                                n.data  = q.shreg & dmask;
                                n.noise = q.nacc | noisy;
                                n.ferr  = ~maj;
                                n.full  = ~q.stby;
                            end
                        end
                        default: ;
                    endcase
                end
                if (q.sub == SUB_LAST) begin
                    case (q.st)
                        RX_START: begin
                            n.st   = RX_DATA;
                            n.bitn = BW'(1);
                        end
                        RX_DATA: begin
                            if (q.bitn == last_bit) n.st   = RX_STOP;
                            else                    n.bitn = q.bitn + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end

        if (idle_clr)      n.stby = 1'b0;
        if (standby_set_i) n.stby = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RX_RESET;
        else         q <= n;
    end

    assign data_o      = q.data;
    assign full_o      = q.full;
    assign noise_o     = q.noise;
    assign frame_err_o = q.ferr;
    assign overrun_o   = q.ovr;
    assign standby_o   = q.stby;
    assign irq_o       = (q.full | q.ovr) & ~q.stby;
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
    parameter int DATA_MAX = 9
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                tick_i,
    input logic                rd_i,
    input logic                standby_set_i,
    input logic [DATA_MAX-1:0] data_o,
    input logic                full_o,
    input logic                noise_o,
    input logic                frame_err_o,
    input logic                overrun_o,
    input logic                standby_o,
    input logic                irq_o
);
    // R10
    standby_blocks_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (standby_o && !full_o) |=> !full_o);

    // R10
    standby_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_set_i |=> standby_o);

    // R8
    data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && !rd_i) |=> $stable(data_o));

    // R9
    read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !tick_i) |=> (!full_o && !overrun_o && !noise_o && !frame_err_o));

    // R5
    full_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(full_o) |-> $past(tick_i));

    // R11
    irq_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(tick_i));

    // R11
    irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_set_i |=> !irq_o);

    // R12
    standby_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(standby_o) |-> ($past(tick_i) && !$past(standby_set_i)));
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_MAX(DATA_MAX)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .rd_i          (rd_i),
    .standby_set_i (standby_set_i),
    .data_o        (data_o),
    .full_o        (full_o),
    .noise_o       (noise_o),
    .frame_err_o   (frame_err_o),
    .overrun_o     (overrun_o),
    .standby_o     (standby_o),
    .irq_o         (irq_o)
);

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       rxd = 1'b1;
    logic       nine = 1'b0;
    logic       sb_set = 1'b0;
    logic       rd = 1'b0;
    logic [8:0] data_o;
    logic       full_o, noise_o, ferr_o, ovr_o, stby_o, irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    uart_os_rx dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .rxd_i(rxd),
        .nine_bit_i(nine), .standby_set_i(sb_set), .rd_i(rd),
        .data_o(data_o), .full_o(full_o), .noise_o(noise_o),
        .frame_err_o(ferr_o), .overrun_o(ovr_o), .standby_o(stby_o), .irq_o(irq_o)
    );

    // tick every fourth clock
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv   = (tdiv + 1) % 4;
        tick_i = (tdiv == 0);
    end

    // ---------------- reference model, tick level ----------------
    bit m_h1, m_h2, m_prev, m_busy, ml, m_nz;
    int m_t, m_nb, m_data, m_icnt;
    bit m_s[$];
    int e_data;
    bit e_full, e_noise, e_ferr, e_ovr, e_stby;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_h1 = 1; m_h2 = 1; m_prev = 1; m_busy = 0; m_t = 0; m_nb = 8;
            m_data = 0; m_nz = 0; m_icnt = 0; m_s.delete();
            e_data = 0; e_full = 0; e_noise = 0; e_ferr = 0; e_ovr = 0; e_stby = 0;
        end else begin
            ml = m_h2; m_h2 = m_h1; m_h1 = rxd;
            if (rd) begin e_full = 0; e_ovr = 0; e_noise = 0; e_ferr = 0; end
            if (tick_i) begin
                if (m_busy) begin
                    int bi, pos;
                    m_icnt = 0;
                    m_t++;
                    bi  = (m_t - 1) / 16;
                    pos = (m_t - 1) % 16 + 1;
                    if (pos == 8 || pos == 9) m_s.push_back(ml);
                    if (pos == 10) begin
                        int ones;
                        bit mj, nz;
                        ones = int'(m_s[0]) + int'(m_s[1]) + int'(ml);
                        mj = (ones >= 2);
                        nz = (ones == 1 || ones == 2);
                        m_s.delete();
                        if (bi == 0) begin
                            if (mj) m_busy = 0; else m_nz = nz;
                        end else if (bi <= m_nb) begin
                            if (mj) m_data = m_data | (1 << (bi - 1));
                            m_nz = m_nz | nz;
                        end else begin
                            m_busy = 0;
                            if (e_full) e_ovr = 1;
                            else begin
                                e_data = m_data; e_noise = m_nz | nz;
                                e_ferr = !mj; e_full = !e_stby;
                            end
                        end
                    end
                end else begin
                    if (m_prev && !ml) begin
                        m_busy = 1; m_t = 1; m_nb = nine ? 9 : 8;
                        m_data = 0; m_nz = 0; m_s.delete(); m_icnt = 0;
                    end else if (ml) begin
                        m_icnt++;
                        if (m_icnt >= (nine ? 176 : 160)) e_stby = 0;
                    end else m_icnt = 0;
                end
                m_prev = ml;
            end
            if (sb_set) begin e_stby = 1; m_icnt = 0; end
        end
    end

    // per-clock comparison (R5 cycle timing and everything else)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_irq;
            e_irq = (e_full || e_ovr) && !e_stby;
            checks++;
            if (data_o !== 9'(e_data) || full_o !== e_full || noise_o !== e_noise ||
                ferr_o !== e_ferr || ovr_o !== e_ovr || stby_o !== e_stby || irq_o !== e_irq) begin
                fails++;
                $display("FAIL R5 model at %0t: act d=%h f=%b n=%b fe=%b o=%b s=%b i=%b exp d=%h f=%b n=%b fe=%b o=%b s=%b i=%b",
                         $time, data_o, full_o, noise_o, ferr_o, ovr_o, stby_o, irq_o,
                         9'(e_data), e_full, e_noise, e_ferr, e_ovr, e_stby, e_irq);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic send(input int val, input bit nb9, input bit stop_v, input int bclk, input int gl_bit);
        bit fr[0:11];
        int nb;
        nb = nb9 ? 9 : 8;
        nine = nb9;
        fr[0] = 0;
        for (int i = 0; i < nb; i++) fr[i+1] = val[i];
        fr[nb+1] = stop_v;
        do @(posedge clk); while (!tick_i);
        @(negedge clk);
        for (int b = 0; b < nb + 2; b++) begin
            for (int c = 0; c < bclk; c++) begin
                rxd = fr[b] ^ (b == gl_bit && c >= 32 && c < 36);
                @(negedge clk);
            end
        end
        rxd = 1;
    endtask

    task automatic read_pulse();
        rd = 1; @(negedge clk); rd = 0; @(negedge clk);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 data", data_o, 0);
        chk("R1 flags", {full_o, noise_o, ferr_o, ovr_o, stby_o, irq_o}, 0);
        wait_clk(200);

        // R3 8-bit character, R11 interrupt
        send(8'hA5, 0, 1, 64, -1);
        chk("R3 data 8-bit", data_o, 9'h0A5);
        chk("R3 full", full_o, 1);
        chk("R11 irq with full", irq_o, 1);
        chk("R3 clean flags", {noise_o, ferr_o, ovr_o}, 0);
        read_pulse();
        chk("R9 full cleared", full_o, 0);
        chk("R11 irq cleared", irq_o, 0);

        // R4 nine-bit character
        send(9'h1C3, 1, 1, 64, -1);
        chk("R4 data 9-bit", data_o, 9'h1C3);
        read_pulse();
        // R3 8-bit after 9-bit: top bit loaded as 0
        send(8'h5A, 0, 1, 64, -1);
        chk("R3 top bit masked", data_o, 9'h05A);
        read_pulse();

        // R8 overrun
        send(8'h11, 0, 1, 64, -1);
        send(8'h22, 0, 1, 64, -1);
        chk("R8 data kept", data_o, 9'h011);
        chk("R8 overrun", ovr_o, 1);
        chk("R8 full kept", full_o, 1);
        read_pulse();
        chk("R9 overrun cleared", ovr_o, 0);

        // R7 framing error
        send(8'h77, 0, 0, 64, -1);
        wait_clk(64);
        chk("R7 frame error", ferr_o, 1);
        chk("R7 data loaded", data_o, 9'h077);
        read_pulse();
        chk("R9 frame error cleared", ferr_o, 0);
        wait_clk(100);

        // R6 noise: glitch on the middle sample of data bit 3
        send(8'h96, 0, 1, 64, 3);
        chk("R6 noise", noise_o, 1);
        chk("R6 data by majority", data_o, 9'h096);
        read_pulse();
        chk("R9 noise cleared", noise_o, 0);

        // R2 false start
        wait_clk(40);
        rxd = 0; wait_clk(16); rxd = 1;
        wait_clk(300);
        chk("R2 false start no full", full_o, 0);
        chk("R2 false start data kept", data_o, 9'h096);

        // R10 standby
        sb_set = 1; @(negedge clk); sb_set = 0;
        chk("R10 standby set", stby_o, 1);
        send(8'h3E, 0, 1, 64, -1);
        chk("R10 data loaded in standby", data_o, 9'h03E);
        chk("R10 full withheld", full_o, 0);
        chk("R11 irq withheld", irq_o, 0);
        wait_clk(64);
        send(8'h4D, 0, 1, 64, -1);
        chk("R12 short gap keeps standby", stby_o, 1);
        chk("R10 second data loaded", data_o, 9'h04D);
        wait_clk(800);
        chk("R12 idle releases standby", stby_o, 0);
        send(8'h6B, 0, 1, 64, -1);
        chk("R10 full resumes", full_o, 1);

        // R11 irq masked by standby while full
        sb_set = 1; @(negedge clk); sb_set = 0;
        @(negedge clk);
        chk("R11 irq masked", irq_o, 0);
        chk("R11 full held", full_o, 1);
        wait_clk(800);
        chk("R12 standby released", stby_o, 0);
        chk("R11 irq restored", irq_o, 1);
        read_pulse();

        // R13 tolerance
        send(9'h155, 1, 1, 62, -1);
        chk("R13 fast 9-bit", {ferr_o, noise_o, data_o}, {2'b00, 9'h155});
        read_pulse();
        send(9'h0AA, 1, 1, 66, -1);
        chk("R13 slow 9-bit", {ferr_o, noise_o, data_o}, {2'b00, 9'h0AA});
        read_pulse();
        send(8'hC3, 0, 1, 62, -1);
        chk("R13 fast 8-bit", {ferr_o, noise_o, data_o}, {2'b00, 9'h0C3});
        read_pulse();
        send(8'h3C, 0, 1, 66, -1);
        chk("R13 slow 8-bit", {ferr_o, noise_o, data_o}, {2'b00, 9'h03C});
        read_pulse();
        wait_clk(100);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule